// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block converts a single pulse-width command into two gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side rectifier switch. Every switch turn-on waits for a dead-time interval, counted in clock cycles, so the two switches never conduct together. A rectifier-enable input selects whether the low-side switch conducts during the low phase. When that input is low, both switches are off in the low phase, which gives diode-emulation behaviour.

A shutdown request from the fault logic turns both switches off and lets the switch node float. A high-impedance indication on the command pin does the same, but only after it has persisted for a programmable number of cycles. After either condition clears, the stage stays off until the next rising edge of the command. Switching then restarts from the beginning of a clean cycle. The command and the high-impedance indication pass through a two-flop synchroniser before they are used.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is low, and after reset until the first synchronised rising edge of `pwm_i`, both enables are 0 and `sw_float_o` is 1.
- R2: With `sync_rect_en_i` = 1, `hs_en_o` goes to 1 exactly 3+HS_DEAD_CYC cycles after `pwm_i` rises. `ls_en_o` goes to 1 exactly 3+LS_DEAD_CYC cycles after `pwm_i` falls.
- R3: The conducting switch turns off 3 cycles after `pwm_i` changes. Both enables then stay 0 for exactly HS_DEAD_CYC cycles before the high side turns on, or LS_DEAD_CYC cycles before the low side turns on.
- R4: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R5: While `sync_rect_en_i` = 0, `ls_en_o` is 0. A drop of `sync_rect_en_i` while the low side conducts clears `ls_en_o` at the next clock edge.
- R6: When `sync_rect_en_i` rises during a low phase, `ls_en_o` goes to 1 after 1+LS_DEAD_CYC cycles.
- R7: A change of the synchronised command during a dead-time interval restarts the count for the opposite switch. No minimum pulse width is enforced: a high pulse of P cycles gives P−HS_DEAD_CYC cycles of `hs_en_o`, or none when P ≤ HS_DEAD_CYC.
- R8: `shutdown_i` = 1 clears both enables at the next clock edge.
- R9: After shutdown is released, both enables stay 0 until a new synchronised rising edge of `pwm_i`. A shutdown seen in the cycle in which a dead time ends prevents that turn-on.
- R10: `pwm_hiz_i` held high clears both enables 3+HIZ_TRIP_CYC cycles after it rises. A burst shorter than HIZ_TRIP_CYC cycles has no effect. After it clears, restart again waits for a rising edge.
- R11: `sw_float_o` is 1 exactly when neither enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Pulse-width command, asynchronous |
| pwm_hiz_i | input | 1 | Command pin detected high-impedance, asynchronous |
| sync_rect_en_i | input | 1 | 1 lets the low side conduct in the low phase |
| shutdown_i | input | 1 | Fault shutdown request, synchronous to `clk_i` |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| sw_float_o | output | 1 | Both switches off, switch node floating |

## Verification
The end of a dead-time interval and a shutdown request can land in the same cycle. The bench raises the command from the low-side conducting state. It then asserts shutdown for one cycle, placed exactly at the clock edge where the high-side dead time expires. It judges the result by checking that `hs_en_o` never rises in that window, and stays low afterwards while the command remains high. A command pulse that ends inside the dead time is provoked in the same way, and is judged by counting the high-side cycles it produces.

// File: rtl/buck_gs_pkg.sv
package buck_gs_pkg;
  typedef enum logic [2:0] {
    ST_HALT,    // all off, wait for rising edge
    ST_DT_HS,   // dead time before high side
    ST_HS_ON,
    ST_DT_LS,   // dead time before low side
    ST_LS_ON,
    ST_LOW_OFF  // low phase, rectifier disabled
  } gate_state_e;
endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 1) begin : g_single
    logic [WIDTH-1:0] stg;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg <= '0;
      else         stg <= d_i;
    assign q_o = stg;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] stg;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg <= '0;
      else         stg <= {stg[STAGES-2:0], d_i};
    assign q_o = stg[STAGES-1];
  end
endmodule

// File: rtl/bgs_hiz_det.sv
module bgs_hiz_det #(
  parameter int HIZ_TRIP_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hiz_s_i,
  output logic trip_o
);
  localparam int CW = $clog2(HIZ_TRIP_CYC + 1);
  localparam logic [CW-1:0] TRIP_VAL = CW'(HIZ_TRIP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= '0;
    else if (!hiz_s_i)         cnt_q <= '0;
    else if (cnt_q != TRIP_VAL) cnt_q <= cnt_q + 1'b1;

  assign trip_o = (cnt_q == TRIP_VAL);

  // R10: a trip is only ever entered out of a persisting high-impedance input
  a_r10_trip_needs_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(hiz_s_i));
endmodule

// File: rtl/bgs_dt_fsm.sv
module bgs_dt_fsm
  import buck_gs_pkg::*;
#(
  parameter int HS_DEAD_CYC = 1,
  parameter int LS_DEAD_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_s_i,
  input  logic halt_i,
  input  logic sre_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int DT_MAX = (HS_DEAD_CYC > LS_DEAD_CYC) ? HS_DEAD_CYC : LS_DEAD_CYC;
  localparam int CW     = $clog2(DT_MAX + 1);
  localparam logic [CW-1:0] HS_LAST = CW'(HS_DEAD_CYC - 1);
  localparam logic [CW-1:0] LS_LAST = CW'(LS_DEAD_CYC - 1);
  localparam logic [CW-1:0] DT_SAT  = CW'(DT_MAX);

  gate_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic pwm_q, rise;

  assign rise = pwm_s_i & ~pwm_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = '0;
    if (halt_i) begin
      st_d = ST_HALT;
    end else begin
      unique case (st_q)
        ST_HALT:  if (rise) st_d = ST_DT_HS;
        ST_DT_HS: begin
          if (!pwm_s_i)              st_d = ST_DT_LS;  // restart count
          else if (cnt_q == HS_LAST) st_d = ST_HS_ON;
          else                       cnt_d = cnt_q + 1'b1;
        end
        ST_HS_ON: if (!pwm_s_i) st_d = ST_DT_LS;
        ST_DT_LS: begin
          if (pwm_s_i)               st_d = ST_DT_HS;
          else if (cnt_q == LS_LAST) st_d = sre_i ? ST_LS_ON : ST_LOW_OFF;
          else                       cnt_d = cnt_q + 1'b1;
        end
        ST_LS_ON: begin
          if (pwm_s_i)     st_d = ST_DT_HS;
          else if (!sre_i) st_d = ST_LOW_OFF;
        end
        ST_LOW_OFF: begin
          if (pwm_s_i)    st_d = ST_DT_HS;
          else if (sre_i) st_d = ST_DT_LS;
        end
        default: st_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= ST_HALT;
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pwm_q <= pwm_s_i;
    end

  assign hs_en_o = (st_q == ST_HS_ON);
  assign ls_en_o = (st_q == ST_LS_ON);

  // length of the current all-off run, for dead-time checks
  logic [CW-1:0] off_run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  off_run_q <= '0;
    else if (hs_en_o || ls_en_o)  off_run_q <= '0;
    else if (off_run_q != DT_SAT) off_run_q <= off_run_q + 1'b1;

  a_r3_hs_dead_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> off_run_q >= CW'(HS_DEAD_CYC));
  a_r3_ls_dead_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> off_run_q >= CW'(LS_DEAD_CYC));
  a_r5_sre_low_ls_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sre_i |=> !ls_en_o);
  a_r9_halt_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !hs_en_o && !ls_en_o);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int HS_DEAD_CYC  = 1,   // 8 ns at 125 MHz
  parameter int LS_DEAD_CYC  = 1,
  parameter int HIZ_TRIP_CYC = 20,  // 3+20 cycles = 184 ns at 125 MHz
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic pwm_hiz_i,
  input  logic sync_rect_en_i,
  input  logic shutdown_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic sw_float_o
);
  logic [1:0] sync_q;
  logic       pwm_s, hiz_s, hiz_trip, halt;

  bgs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pwm_hiz_i, pwm_i}),
    .q_o   (sync_q)
  );
  assign pwm_s = sync_q[0];
  assign hiz_s = sync_q[1];

  bgs_hiz_det #(.HIZ_TRIP_CYC(HIZ_TRIP_CYC)) u_hiz (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hiz_s_i(hiz_s),
    .trip_o (hiz_trip)
  );

  assign halt = shutdown_i | hiz_trip;

  bgs_dt_fsm #(.HS_DEAD_CYC(HS_DEAD_CYC), .LS_DEAD_CYC(LS_DEAD_CYC)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_s_i(pwm_s),
    .halt_i (halt),
    .sre_i  (sync_rect_en_i),
    .hs_en_o(hs_en_o),
    .ls_en_o(ls_en_o)
  );

  assign sw_float_o = ~(hs_en_o | ls_en_o);

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));
  a_r8_shutdown_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> !hs_en_o && !ls_en_o);
  a_r10_hiz_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_trip |=> !hs_en_o && !ls_en_o);
endmodule

// File: tb/buck_gate_seq_test.sv
module buck_gate_seq_test;
  localparam int HS_DT = 2;
  localparam int LS_DT = 3;
  localparam int HIZ_N = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pwm = 1'b0, hiz = 1'b0, sre = 1'b1, sd = 1'b0;
  logic hs, ls, fl;
  int tests = 0, fails = 0, overlaps = 0;

  always #4 clk = ~clk;  // 125 MHz

  buck_gate_seq #(.HS_DEAD_CYC(HS_DT), .LS_DEAD_CYC(LS_DT), .HIZ_TRIP_CYC(HIZ_N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .pwm_hiz_i(hiz),
    .sync_rect_en_i(sre), .shutdown_i(sd),
    .hs_en_o(hs), .ls_en_o(ls), .sw_float_o(fl)
  );

  typedef struct packed {
    logic [3:0] req;
    logic pwm, sre, sd, hiz;
    logic [7:0] wt;
    logic hs, ls, fl;
  } vec_t;

  // req, pwm, sre, sd, hiz, wait, hs, ls, float
  localparam vec_t VEC [15] = '{
    '{4'd1,  1'b0, 1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1}, // R1 no edge yet
    '{4'd2,  1'b1, 1'b1, 1'b0, 1'b0, 8'd8,  1'b1, 1'b0, 1'b0}, // R2 high side
    '{4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 1'b1, 1'b0}, // R2 low side
    '{4'd5,  1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 1'b1}, // R5 sre drop
    '{4'd2,  1'b1, 1'b0, 1'b0, 1'b0, 8'd8,  1'b1, 1'b0, 1'b0}, // R2
    '{4'd5,  1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1}, // R5 diode emulation
    '{4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 8'd6,  1'b0, 1'b1, 1'b0}, // R6 sre rise
    '{4'd8,  1'b1, 1'b1, 1'b1, 1'b0, 8'd3,  1'b0, 1'b0, 1'b1}, // R8 shutdown
    '{4'd9,  1'b1, 1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1}, // R9 no edge
    '{4'd9,  1'b0, 1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1}, // R9 no low side
    '{4'd9,  1'b1, 1'b1, 1'b0, 1'b0, 8'd8,  1'b1, 1'b0, 1'b0}, // R9 resume
    '{4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 8'd10, 1'b0, 1'b0, 1'b1}, // R10 trip
    '{4'd10, 1'b1, 1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1}, // R10 no edge
    '{4'd10, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0, 1'b1}, // R10
    '{4'd10, 1'b1, 1'b1, 1'b0, 1'b0, 8'd8,  1'b1, 1'b0, 1'b0}  // R10 resume
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R4: overlap monitor on every cycle
  always @(negedge clk) if (rst_ni && hs && ls) overlaps++;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic pulse_count(input int p, output int n);
    n = 0;
    @(negedge clk); pwm = 1'b1;
    for (int i = 0; i < p; i++) begin @(negedge clk); n += int'(hs); end
    pwm = 1'b0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); n += int'(hs); end
  endtask

  initial begin
    int n;
    step(2);
    check("R1", "hs in reset", hs, 0);
    check("R1", "ls in reset", ls, 0);
    check("R11", "float in reset", fl, 1);
    rst_ni = 1'b1;

    foreach (VEC[i]) begin
      pwm = VEC[i].pwm; sre = VEC[i].sre; sd = VEC[i].sd; hiz = VEC[i].hiz;
      step(VEC[i].wt);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d hs", i), hs, VEC[i].hs);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d ls", i), ls, VEC[i].ls);
      check("R11", $sformatf("vec %0d float", i), fl, VEC[i].fl);
    end

    // R2/R3 exact latency, low side -> high side
    pwm = 1'b0; sre = 1'b1; step(10);
    pwm = 1'b1;
    step(2); check("R3", "ls before turn-off", ls, 1);
    step(1); check("R3", "ls off at 3", ls, 0);
    check("R3", "hs in dead time", hs, 0);
    step(1); check("R3", "hs dead cycle 2", hs, 0);
    step(1); check("R2", "hs on at 3+HS_DT", hs, 1);
    // high side -> low side
    step(5); pwm = 1'b0;
    step(2); check("R3", "hs before turn-off", hs, 1);
    step(1); check("R3", "hs off at 3", hs, 0);
    step(2); check("R3", "ls dead cycle 3", ls, 0);
    step(1); check("R2", "ls on at 3+LS_DT", ls, 1);

    // R7 pulse widths, no minimum
    step(4);
    pulse_count(HS_DT, n);      check("R7", "pulse P=HS_DT hs cycles", n, 0);
    pulse_count(HS_DT + 1, n);  check("R7", "pulse P=HS_DT+1 hs cycles", n, 1);
    pulse_count(8, n);          check("R7", "pulse P=8 hs cycles", n, 8 - HS_DT);
    check("R7", "ls back after pulse", ls, 1);

    // R9 shutdown in the cycle the high-side dead time ends
    step(4);
    pwm = 1'b1; n = 0;
    step(4); sd = 1'b1; n += int'(hs);
    step(1); sd = 1'b0;
    for (int i = 0; i < 12; i++) begin step(1); n += int'(hs); end
    check("R9", "hs cycles after coincident shutdown", n, 0);
    pwm = 1'b0; step(6);
    pwm = 1'b1; step(5);
    check("R9", "hs after fresh edge", hs, 1);

    // R8 exact latency
    sd = 1'b1;
    check("R8", "hs before edge", hs, 1);
    step(1); check("R8", "hs off next edge", hs, 0);
    sd = 1'b0; pwm = 1'b0; step(6); pwm = 1'b1; step(8);

    // R10 short burst ignored, full burst trips at 3+HIZ_N
    n = 0; hiz = 1'b1;
    step(HIZ_N - 1); hiz = 1'b0;
    for (int i = 0; i < 10; i++) begin step(1); n += int'(hs); end
    check("R10", "hs cycles through short burst", n, 10 + HIZ_N - HIZ_N);
    hiz = 1'b1;
    step(3 + HIZ_N - 1); check("R10", "hs one cycle before trip", hs, 1);
    step(1); check("R10", "hs off at 3+HIZ_N", hs, 0);
    check("R11", "float on trip", fl, 1);
    hiz = 1'b0; step(2);

    check("R4", "overlap cycles", overlaps, 0);
    summary();
  end
endmodule